// File: doc/BRIEF.md
# Vertical Border and Text Row Controller

This block decides, one raster line at a time, whether the vertical border covers the picture, and whether a text row is being drawn. It looks at the current raster line only when the start-of-line strobe is high. It compares that line with two programmable lines. One is the line where the lower border begins. The other is the line where the upper border ends.

The border flag is a set/reset flip-flop, not a window test. It is set only on the exact line that equals the lower-border line. It is cleared only on the exact line that equals the upper-border line. If software moves the lower-border line to a value the raster never reaches, the border opens at the upper-border line and stays open from frame to frame. The areas above and below the picture can then show content.

The display can have more text rows than the usual picture holds. A second part of the block therefore counts text rows from the upper-border line, and clears a text-active flag once a programmable row limit is reached. Rows beyond the limit then show border or background, not stray characters. The row limit is a register with a write strobe, and it resets to 25.

Top module: `vborder_ctrl`

## Requirements
- R1: After reset, `vborder` is 1, `text_on` is 0 and `text_row` is 0, and the row limit is 25. With that limit and 8 lines per row, exactly 200 lines starting at the upper-border line show `text_on` = 1.
- R2: A start-of-line strobe whose `raster_line` equals `bot_line` makes `vborder` 1 from the next clock.
- R3: A strobe whose `raster_line` equals `top_line`, and does not equal `bot_line`, makes `vborder` 0 from the next clock.
- R4: A strobe that matches neither line leaves `vborder` unchanged. If `bot_line` is never reached, the border stays open through later frames.
- R5: Without a strobe, `vborder`, `text_on` and `text_row` do not change, whatever the raster and compare inputs show.
- R6: A strobe that matches `top_line` sets `text_row` to 0 and the line-in-row count to 0. It sets `text_on` to 1 if the row limit is nonzero, and to 0 if the limit is 0.
- R7: While `text_on` is 1, every strobe that does not match `top_line` advances the line-in-row count. After `ROW_LINES` strobes, `text_row` increments. When the incremented row is greater than or equal to the limit, `text_on` clears.
- R8: When `cfg_we` is high at a clock, `cfg_rows` is loaded as the row limit. Later frames then draw exactly limit × `ROW_LINES` text lines.
- R9: When `top_line` equals `bot_line`, a strobe on that line sets `vborder` to 1, and text rows still restart as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle strobe at the start of each raster line |
| raster_line | input | LINE_W | Current raster line, valid with the strobe |
| top_line | input | LINE_W | Line on which the upper border ends |
| bot_line | input | LINE_W | Line on which the lower border begins |
| cfg_we | input | 1 | Write strobe for the row limit |
| cfg_rows | input | ROW_W | New row limit |
| vborder | output | 1 | Vertical border flag |
| text_on | output | 1 | A text row is being drawn on this line |
| text_row | output | ROW_W | Index of the current text row |

## Verification
The hardest state to reach is an open border that persists: the lower-border line must be skipped for whole frames, and a correct design gives no sign of this except a flag that does not move. The stimulus moves `bot_line` past the end of the frame, or to a random value that may or may not be reached, and runs several frames in a row.

During the idle cycles between strobes, the stimulus also sets the raster input to the compare values. This shows that a match without a strobe has no effect. Coincident compare lines and a zero row limit are driven as directed cases.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef enum logic [1:0] {
    VB_EV_NONE  = 2'd0,
    VB_EV_OPEN  = 2'd1,
    VB_EV_CLOSE = 2'd2
  } vb_ev_e;
endpackage

// File: rtl/vbc_event_detect.sv
module vbc_event_detect #(
  parameter int LINE_W = 9
) (
  input  logic              line_start,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [LINE_W-1:0] top_line,
  input  logic [LINE_W-1:0] bot_line,
  output logic              hit_top,
  output logic              hit_bot,
  output vbc_pkg::vb_ev_e   border_ev
);
  import vbc_pkg::*;

  function automatic logic line_hit(input logic strobe,
                                    input logic [LINE_W-1:0] cur,
                                    input logic [LINE_W-1:0] ref_line);
    return strobe && (cur == ref_line);
  endfunction

  always_comb begin
    hit_top = line_hit(line_start, raster_line, top_line);
    hit_bot = line_hit(line_start, raster_line, bot_line);
    // closing the border wins when both lines coincide
    if (hit_bot)      border_ev = VB_EV_CLOSE;
    else if (hit_top) border_ev = VB_EV_OPEN;
    else              border_ev = VB_EV_NONE;
  end
endmodule

// File: rtl/vbc_border_latch.sv
module vbc_border_latch (
  input  logic            clk,
  input  logic            rst_n,
  input  vbc_pkg::vb_ev_e border_ev,
  output logic            vborder
);
  import vbc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vborder <= 1'b1;
    end else begin
      case (border_ev)
        VB_EV_CLOSE: vborder <= 1'b1;
        VB_EV_OPEN:  vborder <= 1'b0;
        default:     vborder <= vborder;
      endcase
    end
  end
endmodule

// File: rtl/vbc_text_rows.sv
module vbc_text_rows #(
  parameter int ROW_W     = 6,
  parameter int ROW_LINES = 8,
  parameter int DEF_ROWS  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             hit_top,
  input  logic             cfg_we,
  input  logic [ROW_W-1:0] cfg_rows,
  output logic             text_on,
  output logic [ROW_W-1:0] text_row,
  output logic [ROW_W-1:0] row_limit
);
  localparam int SUB_W = (ROW_LINES > 1) ? $clog2(ROW_LINES) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(ROW_LINES - 1);

  logic [SUB_W-1:0] sub_q;
  logic             row_done;
  logic [ROW_W-1:0] row_next;
  logic             rows_spent;

  function automatic logic limit_reached(input logic [ROW_W-1:0] row,
                                         input logic [ROW_W-1:0] lim);
    return row >= lim;
  endfunction

  assign row_done   = (sub_q == SUB_LAST);
  assign row_next   = ROW_W'(text_row + 1'b1);
  assign rows_spent = limit_reached(row_next, row_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_limit <= ROW_W'(DEF_ROWS);
    end else if (cfg_we) begin
      row_limit <= cfg_rows;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      text_on  <= 1'b0;
      text_row <= '0;
      sub_q    <= '0;
    end else if (line_start) begin
      if (hit_top) begin
        text_on  <= (row_limit != '0);
        text_row <= '0;
        sub_q    <= '0;
      end else if (text_on) begin
        if (row_done) begin
          sub_q    <= '0;
          text_row <= row_next;
          if (rows_spent) text_on <= 1'b0;
        end else begin
          sub_q <= SUB_W'(sub_q + 1'b1);
        end
      end
    end
  end
endmodule

// File: rtl/vborder_ctrl.sv
module vborder_ctrl #(
  parameter int LINE_W    = 9,
  parameter int ROW_W     = 6,
  parameter int ROW_LINES = 8,
  parameter int DEF_ROWS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [LINE_W-1:0] top_line,
  input  logic [LINE_W-1:0] bot_line,
  input  logic              cfg_we,
  input  logic [ROW_W-1:0]  cfg_rows,
  output logic              vborder,
  output logic              text_on,
  output logic [ROW_W-1:0]  text_row
);
  // named internal events, observed by the bound checker
  logic             hit_top;
  logic             hit_bot;
  logic [ROW_W-1:0] row_limit;
  vbc_pkg::vb_ev_e  border_ev;

  vbc_event_detect #(.LINE_W(LINE_W)) u_detect (
    .line_start  (line_start),
    .raster_line (raster_line),
    .top_line    (top_line),
    .bot_line    (bot_line),
    .hit_top     (hit_top),
    .hit_bot     (hit_bot),
    .border_ev   (border_ev)
  );

  vbc_border_latch u_border (
    .clk       (clk),
    .rst_n     (rst_n),
    .border_ev (border_ev),
    .vborder   (vborder)
  );

  vbc_text_rows #(
    .ROW_W     (ROW_W),
    .ROW_LINES (ROW_LINES),
    .DEF_ROWS  (DEF_ROWS)
  ) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .hit_top    (hit_top),
    .cfg_we     (cfg_we),
    .cfg_rows   (cfg_rows),
    .text_on    (text_on),
    .text_row   (text_row),
    .row_limit  (row_limit)
  );
endmodule

// File: rtl/vborder_ctrl_chk.sv
module vborder_ctrl_chk #(
  parameter int ROW_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             ev_top,
  input logic             ev_bot,
  input logic             vborder,
  input logic             text_on,
  input logic [ROW_W-1:0] text_row,
  input logic [ROW_W-1:0] row_limit
);
  AST_BORDER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bot |=> vborder); // R2
  AST_BORDER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_top && !ev_bot) |=> !vborder); // R3
  AST_BORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_top && !ev_bot) |=> $stable(vborder)); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(text_on) && $stable(text_row))); // R5
  AST_TEXT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_top && row_limit != '0) |=> (text_on && text_row == '0)); // R6
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !ev_top && text_on) |=>
      (text_row == $past(text_row) || text_row == ROW_W'($past(text_row) + 1'b1))); // R7
  AST_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_top && ev_bot) |=> (vborder && text_row == '0)); // R9
endmodule

bind vborder_ctrl vborder_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .ev_top     (hit_top),
  .ev_bot     (hit_bot),
  .vborder    (vborder),
  .text_on    (text_on),
  .text_row   (text_row),
  .row_limit  (row_limit)
);

// File: tb/tb_vborder_ctrl.sv
module tb_vborder_ctrl;
  localparam int LINE_W = 9;
  localparam int ROW_W  = 6;
  localparam int RL     = 8;
  localparam int FRAME  = 260;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              line_start = 1'b0;
  logic [LINE_W-1:0] raster_line = '0;
  logic [LINE_W-1:0] top_line = '0;
  logic [LINE_W-1:0] bot_line = '0;
  logic              cfg_we = 1'b0;
  logic [ROW_W-1:0]  cfg_rows = '0;
  logic              vborder;
  logic              text_on;
  logic [ROW_W-1:0]  text_row;

  vborder_ctrl #(.LINE_W(LINE_W), .ROW_W(ROW_W), .ROW_LINES(RL), .DEF_ROWS(25)) dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .raster_line(raster_line),
    .top_line(top_line), .bot_line(bot_line), .cfg_we(cfg_we), .cfg_rows(cfg_rows),
    .vborder(vborder), .text_on(text_on), .text_row(text_row));

  always #10 clk = ~clk; // 50 MHz

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of the requirements
  bit m_border = 1'b1;
  bit m_text   = 1'b0;
  int m_row    = 0;
  int m_lines  = 0; // lines already drawn inside the current row
  int m_limit  = 25;
  int tally    = 0; // strobes after which text_on was seen high

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic void model_line(input int r);
    bit at_top = (r == int'(top_line));
    bit at_bot = (r == int'(bot_line));
    if (at_bot) m_border = 1'b1;
    else if (at_top) m_border = 1'b0;
    if (at_top) begin
      m_row = 0; m_lines = 0; m_text = (m_limit > 0);
    end else if (m_text) begin
      m_lines++;
      if (m_lines == RL) begin
        m_lines = 0;
        m_row++;
        if (m_row >= m_limit) m_text = 1'b0;
      end
    end
  endfunction

  task automatic step_line(input int r);
    string rb, rt;
    bit at_top, at_bot;
    int gap;
    @(negedge clk);
    line_start  = 1'b1;
    raster_line = LINE_W'(r);
    at_top = (r == int'(top_line));
    at_bot = (r == int'(bot_line));
    @(posedge clk);
    model_line(r);
    @(negedge clk);
    line_start = 1'b0;
    rb = (at_top && at_bot) ? "R9" : at_bot ? "R2" : at_top ? "R3" : "R4";
    rt = at_top ? "R6" : "R7";
    check(rb, vborder, m_border);
    check(rt, text_on, m_text);
    check(rt, text_row, m_row);
    if (text_on) tally++;
    gap = 1 + int'($urandom % 2);
    for (int g = 0; g < gap; g++) begin
      // bait: matching line values without a strobe must do nothing
      raster_line = ($urandom % 2) ? bot_line : top_line;
      @(negedge clk);
      check("R5", vborder, m_border);
      check("R5", text_on, m_text);
      check("R5", text_row, m_row);
    end
  endtask

  task automatic run_frame(input int nlines);
    tally = 0;
    for (int r = 0; r < nlines; r++) step_line(r);
  endtask

  task automatic write_rows(input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rows = ROW_W'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    m_limit = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    #35;
    // R1: reset state
    check("R1", vborder, 1);
    check("R1", text_on, 0);
    check("R1", text_row, 0);
    rst_n = 1'b1;

    // R1: default limit of 25 rows gives 200 text lines
    top_line = 9'd0; bot_line = 9'd240;
    run_frame(FRAME);
    check("R1", tally, 25 * RL);

    // R4: bottom line never reached, border stays open over frames
    bot_line = 9'd400;
    run_frame(FRAME);
    check("R4", vborder, 0);
    top_line = 9'd30;
    run_frame(FRAME);
    check("R4", vborder, 0);

    // R8: new row limit
    write_rows(3);
    run_frame(FRAME);
    check("R8", tally, 3 * RL);

    // R6: zero row limit draws no text
    write_rows(0);
    run_frame(FRAME);
    check("R6", tally, 0);

    // R9: coincident compare lines
    write_rows(4);
    top_line = 9'd50; bot_line = 9'd50;
    run_frame(FRAME);
    check("R9", vborder, 1);

    // random frames
    for (int f = 0; f < 14; f++) begin
      top_line = LINE_W'($urandom % FRAME);
      bot_line = LINE_W'($urandom % 320);
      if ($urandom % 3 == 0) write_rows(int'($urandom % 40));
      run_frame(FRAME);
    end
    finish_run();
  end
endmodule